// File: doc/BRIEF.md
# Bus Arithmetic Unit with Latched Condition

This block is the arithmetic stage of a multicycle datapath that moves every value over one shared 32-bit bus. Two operand registers, A and B, each take the bus value when their own load strobe is high. A 2-bit function select picks one of four operations on A and B. While the result driver is enabled, the result is placed on the bus.

A purely combinational condition circuit watches the bus as it is resolved inside the block. It reports either "non-zero" or "signed less-than", chosen by a type bit. When the result driver carries A−B, these two tests mean A≠B and A<B. The condition is captured in a 1-bit compare register. That register goes to the sequencing logic and can also be driven onto the bus as a zero-extended word, so a set-on-less-than result can be written back.

The shared bus is modelled as a pair of ports. `bus_i` is the value other sources drive. `bus_o` is this block's contribution, and `bus_drv_o` says whether that contribution is valid. Inside the block, the resolved bus is this block's own output when one of its drivers is enabled, and `bus_i` otherwise.

Top module: `bus_alu_cmp`

## Requirements
- R1: Operand register A (or B) takes `bus_i` at a rising clock edge only when `ld_a_i` (or `ld_b_i`) is high, and holds its value otherwise.
- R2: With `fn_i` = 2'b00 the result is A+B modulo 2^32.
- R3: With `fn_i` = 2'b01 the result is A−B modulo 2^32.
- R4: With `fn_i` = 2'b10 the result is the bitwise NAND of A and B.
- R5: With `fn_i` = 2'b11 the result is A+1 modulo 2^32, and B has no effect.
- R6: `bus_o` carries the result only while `drv_alu_i` is high. With neither driver enabled, `bus_o` is zero and `bus_drv_o` is low.
- R7: With `cond_lt_i` = 0 the condition is true exactly when the resolved bus is non-zero. The resolved bus is this block's output when it drives, and `bus_i` otherwise.
- R8: With `cond_lt_i` = 1 and the bus carrying A−B, the condition is true exactly when A is less than B as signed 32-bit values, including the cases where the subtraction overflows.
- R9: The compare register takes the condition at a rising edge when `ld_cmp_i` is high, holds it otherwise, and is visible on `cmp_o`.
- R10: While `drv_cmp_i` is high, `bus_o` equals the compare register zero-extended to 32 bits.
- R11: Asynchronous reset (`rst_ni` low) clears A, B and the compare register to 0.
- R12: `bus_drv_o` is high whenever either driver is enabled. The two drivers are never enabled in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_i | input | 32 | Bus value from other sources |
| ld_a_i | input | 1 | Load operand A from the bus |
| ld_b_i | input | 1 | Load operand B from the bus |
| fn_i | input | 2 | Function select: 00 add, 01 subtract, 10 nand, 11 increment A |
| drv_alu_i | input | 1 | Drive the result onto the bus |
| cond_lt_i | input | 1 | Condition type: 0 non-zero, 1 signed less-than |
| ld_cmp_i | input | 1 | Capture the condition into the compare register |
| drv_cmp_i | input | 1 | Drive the zero-extended compare register onto the bus |
| bus_o | output | 32 | This block's bus contribution |
| bus_drv_o | output | 1 | High when bus_o is being driven |
| cmp_o | output | 1 | Compare register |

## Verification
The assertions assume that the control inputs never enable both drivers in the same cycle. They also assume that the less-than test is judged only when the bus carries the subtraction of the current operands. The bench keeps to both assumptions: every driver phase enables exactly one source, and a monitor counts any overlap as a failure. Less-than captures are requested only together with the subtract function on the result driver. Non-zero captures are exercised both on this block's own result and on a value arriving over `bus_i` with no driver enabled.

// File: rtl/bus_alu_pkg.sv
package bus_alu_pkg;
  typedef enum logic [1:0] {
    FN_ADD  = 2'b00,
    FN_SUB  = 2'b01,
    FN_NAND = 2'b10,
    FN_INC  = 2'b11
  } alu_fn_e;
endpackage

// File: rtl/bus_opnd_reg.sv
module bus_opnd_reg #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= '0;
    else if (ld_i) q_q <= d_i;
  end

  assign q_o = q_q;

  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> $stable(q_o));
  p_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> q_o == $past(d_i));
endmodule

// File: rtl/bus_alu_fn.sv
module bus_alu_fn
  import bus_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [1:0]   fn_i,
  output logic [W-1:0] res_o,
  output logic         sub_ovf_o
);
  localparam int MSB = W - 1;

  logic [W-1:0] diff;
  alu_fn_e      fn;

  assign fn   = alu_fn_e'(fn_i);
  assign diff = a_i - b_i;

  // signed overflow of a-b: operands differ in sign and result sign flips from a
  assign sub_ovf_o = (a_i[MSB] ^ b_i[MSB]) & (diff[MSB] ^ a_i[MSB]);

  always_comb begin
    unique case (fn)
      FN_ADD:  res_o = a_i + b_i;
      FN_SUB:  res_o = diff;
      FN_NAND: res_o = ~(a_i & b_i);
      FN_INC:  res_o = a_i + W'(1);
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/bus_cmp_reg.sv
module bus_cmp_reg #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] bus_val_i,
  input  logic         sub_ovf_i,
  input  logic         lt_sel_i,
  input  logic         ld_i,
  output logic         cmp_o
);
  localparam int MSB = W - 1;

  logic cond;
  logic cmp_q;

  // less-than: sign of difference corrected by overflow
  assign cond = lt_sel_i ? (bus_val_i[MSB] ^ sub_ovf_i) : (|bus_val_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cmp_q <= 1'b0;
    else if (ld_i) cmp_q <= cond;
  end

  assign cmp_o = cmp_q;

  p_cmp_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> $stable(cmp_o));
  p_ne_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i && !lt_sel_i |=> cmp_o == ($past(bus_val_i) != '0));
endmodule

// File: rtl/bus_alu_cmp.sv
module bus_alu_cmp
  import bus_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] bus_i,
  input  logic         ld_a_i,
  input  logic         ld_b_i,
  input  logic [1:0]   fn_i,
  input  logic         drv_alu_i,
  input  logic         cond_lt_i,
  input  logic         ld_cmp_i,
  input  logic         drv_cmp_i,
  output logic [W-1:0] bus_o,
  output logic         bus_drv_o,
  output logic         cmp_o
);
  localparam int N_OPND = 2;

  logic [N_OPND-1:0]        opnd_ld;
  logic [N_OPND-1:0][W-1:0] opnd_q;
  logic [W-1:0]             alu_res;
  logic                     sub_ovf;
  logic [W-1:0]             cmp_word;
  logic [W-1:0]             bus_val;

  assign opnd_ld = {ld_b_i, ld_a_i};

  for (genvar gi = 0; gi < N_OPND; gi++) begin : g_opnd
    bus_opnd_reg #(.W(W)) u_opnd (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ld_i   (opnd_ld[gi]),
      .d_i    (bus_i),
      .q_o    (opnd_q[gi])
    );
  end

  bus_alu_fn #(.W(W)) u_fn (
    .a_i       (opnd_q[0]),
    .b_i       (opnd_q[1]),
    .fn_i      (fn_i),
    .res_o     (alu_res),
    .sub_ovf_o (sub_ovf)
  );

  assign cmp_word  = {{(W-1){1'b0}}, cmp_o};
  assign bus_drv_o = drv_alu_i | drv_cmp_i;

  always_comb begin
    if (drv_alu_i)      bus_o = alu_res;
    else if (drv_cmp_i) bus_o = cmp_word;
    else                bus_o = '0;
  end

  assign bus_val = bus_drv_o ? bus_o : bus_i;

  bus_cmp_reg #(.W(W)) u_cmp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bus_val_i (bus_val),
    .sub_ovf_i (sub_ovf),
    .lt_sel_i  (cond_lt_i),
    .ld_i      (ld_cmp_i),
    .cmp_o     (cmp_o)
  );

  p_one_drv_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(drv_alu_i && drv_cmp_i));
  p_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drv_alu_i && !drv_cmp_i |-> bus_o == '0 && !bus_drv_o);
  p_cmp_word_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_cmp_i && !drv_alu_i |-> bus_o[W-1:1] == '0 && bus_o[0] == cmp_o);
  p_slt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_alu_i && fn_i == FN_SUB && ld_cmp_i && cond_lt_i
      |=> cmp_o == ($signed($past(opnd_q[0])) < $signed($past(opnd_q[1]))));
endmodule

// File: tb/bus_alu_cmp_tb.sv
module bus_alu_cmp_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic [1:0]  fn;
    logic        lt;
    logic [31:0] res;
    logic        cmp;
  } vec_t;

  // fn: 00 add, 01 sub, 10 nand, 11 inc; lt=1 only with sub
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0005, 32'h0000_0007, 2'b00, 1'b0, 32'h0000_000C, 1'b1}, // R2
    '{32'hFFFF_FFFF, 32'h0000_0001, 2'b00, 1'b0, 32'h0000_0000, 1'b0}, // R2 R7
    '{32'h0000_0009, 32'h0000_0009, 2'b01, 1'b0, 32'h0000_0000, 1'b0}, // R3 R7
    '{32'h0000_0003, 32'h0000_0008, 2'b01, 1'b1, 32'hFFFF_FFFB, 1'b1}, // R3 R8
    '{32'h0000_0008, 32'h0000_0003, 2'b01, 1'b1, 32'h0000_0005, 1'b0}, // R8
    '{32'h8000_0000, 32'h0000_0001, 2'b01, 1'b1, 32'h7FFF_FFFF, 1'b1}, // R8 ovf
    '{32'h7FFF_FFFF, 32'hFFFF_FFFF, 2'b01, 1'b1, 32'h8000_0000, 1'b0}, // R8 ovf
    '{32'h0000_0005, 32'h0000_0005, 2'b01, 1'b1, 32'h0000_0000, 1'b0}, // R8 equal
    '{32'hF0F0_F0F0, 32'hFF00_FF00, 2'b10, 1'b0, 32'h0FFF_0FFF, 1'b1}, // R4
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b10, 1'b0, 32'h0000_0000, 1'b0}, // R4
    '{32'hFFFF_FFFF, 32'h0000_0123, 2'b11, 1'b0, 32'h0000_0000, 1'b0}, // R5
    '{32'h0000_0041, 32'hDEAD_0000, 2'b11, 1'b0, 32'h0000_0042, 1'b1}  // R5
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] bus_i = '0;
  logic        ld_a_i = 1'b0, ld_b_i = 1'b0;
  logic [1:0]  fn_i = 2'b00;
  logic        drv_alu_i = 1'b0, cond_lt_i = 1'b0, ld_cmp_i = 1'b0, drv_cmp_i = 1'b0;
  logic [31:0] bus_o;
  logic        bus_drv_o, cmp_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bus_alu_cmp u_dut (
    .clk_i, .rst_ni, .bus_i, .ld_a_i, .ld_b_i, .fn_i, .drv_alu_i,
    .cond_lt_i, .ld_cmp_i, .drv_cmp_i, .bus_o, .bus_drv_o, .cmp_o
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R12 contention monitor
  always @(negedge clk_i) begin
    if (rst_ni && drv_alu_i && drv_cmp_i) begin
      n_fail++;
      $display("FAIL R12 actual=%h expected=%h", 32'h1, 32'h0);
    end
  end

  task automatic load_ab(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk_i); bus_i = a; ld_a_i = 1'b1;
    @(negedge clk_i); bus_i = b; ld_a_i = 1'b0; ld_b_i = 1'b1;
    @(negedge clk_i); ld_b_i = 1'b0; bus_i = 32'hA5A5_5A5A;
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    check(cmp_o == 1'b0, "R11 cmp in reset", {31'b0, cmp_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    fn_i = 2'b00; drv_alu_i = 1'b1; #1;
    check(bus_o == 32'h0, "R11 A+B after reset", bus_o, 32'h0);
    check(bus_drv_o == 1'b1, "R12 drv flag alu", {31'b0, bus_drv_o}, 32'h1);
    drv_alu_i = 1'b0; #1;
    check(bus_o == 32'h0 && !bus_drv_o, "R6 idle bus", bus_o, 32'h0);

    for (int i = 0; i < NV; i++) begin
      load_ab(VECS[i].a, VECS[i].b);
      fn_i = VECS[i].fn; cond_lt_i = VECS[i].lt;
      drv_alu_i = 1'b1; ld_cmp_i = 1'b1; #1;
      check(bus_o == VECS[i].res, $sformatf("R2-5 vec%0d result", i), bus_o, VECS[i].res);
      @(negedge clk_i);
      drv_alu_i = 1'b0; ld_cmp_i = 1'b0; #1;
      check(cmp_o == VECS[i].cmp, $sformatf("R7/R8/R9 vec%0d cmp", i),
            {31'b0, cmp_o}, {31'b0, VECS[i].cmp});
      check(bus_o == 32'h0, $sformatf("R6 vec%0d released", i), bus_o, 32'h0);
      drv_cmp_i = 1'b1; #1;
      check(bus_o == {31'b0, VECS[i].cmp} && bus_drv_o,
            $sformatf("R10 vec%0d cmp word", i), bus_o, {31'b0, VECS[i].cmp});
      @(negedge clk_i); drv_cmp_i = 1'b0;
    end

    // R1: operands hold while bus changes without load
    load_ab(32'd10, 32'd20);
    bus_i = 32'h1234_5678;
    repeat (2) @(negedge clk_i);
    fn_i = 2'b00; drv_alu_i = 1'b1; #1;
    check(bus_o == 32'd30, "R1 hold A B", bus_o, 32'd30);
    drv_alu_i = 1'b0;

    // R7 on external bus value, no driver enabled
    @(negedge clk_i); bus_i = 32'h0000_0100; cond_lt_i = 1'b0; ld_cmp_i = 1'b1;
    @(negedge clk_i); ld_cmp_i = 1'b0; #1;
    check(cmp_o == 1'b1, "R7 external non-zero", {31'b0, cmp_o}, 32'h1);

    // R9 hold: zero bus, no load, cmp unchanged
    bus_i = 32'h0;
    repeat (2) @(negedge clk_i); #1;
    check(cmp_o == 1'b1, "R9 hold", {31'b0, cmp_o}, 32'h1);
    ld_cmp_i = 1'b1;
    @(negedge clk_i); ld_cmp_i = 1'b0; #1;
    check(cmp_o == 1'b0, "R7 external zero", {31'b0, cmp_o}, 32'h0);

    // R11: async reset mid-run
    bus_i = 32'h1; ld_cmp_i = 1'b1;
    @(negedge clk_i); ld_cmp_i = 1'b0;
    load_ab(32'h55, 32'h66);
    #1 rst_ni = 1'b0; #1;
    check(cmp_o == 1'b0, "R11 async clear cmp", {31'b0, cmp_o}, 32'h0);
    @(negedge clk_i); rst_ni = 1'b1; fn_i = 2'b00; drv_alu_i = 1'b1; #1;
    check(bus_o == 32'h0, "R11 async clear A B", bus_o, 32'h0);
    drv_alu_i = 1'b0;

    @(negedge clk_i);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule